// File: doc/BRIEF.md
# Tagged Two-Entry FIFO Register File for a Floppy Data Controller

This block is the register set that a processor uses to talk to a floppy data controller. At its centre is a two-deep FIFO. Each FIFO entry holds a byte plus three tags:

- **mark**: the byte is an address mark.
- **insert-CRC**: the entry is a token that asks the serializer to emit the running CRC.
- **CRC-was-zero**: set by the deserializer when the check value came out zero.

The processor pushes entries by writing three registers and pops them by reading two. The external bit serializer and deserializer reach the same FIFO through a push port and a pop port.

Around the FIFO sit four more pieces of state:

- A sticky error register that keeps only the first error reported.
- A sixteen-entry parameter RAM behind one register address. Its index advances after every access.
- A mode register. It is written through a clear-bits address and a set-bits address. It sets the transfer direction, flushes the FIFO, and drives the drive-select and head-select outputs.
- A read-only handshake register. It reports FIFO level, the tags of the newest entry, write protect and pending errors. Its level coding depends on the transfer direction.

All register access is a single-cycle strobe on a 3-bit address. Read data is combinational while the read strobe is high. Side effects (pop, clear, index advance) take place at the clock edge that ends the access.

Top module: `fdc_regset`

## Requirements
- R1: A FIFO entry is 11 bits: byte in bits 7:0, mark tag at bit 8, insert-CRC tag at bit 9 and CRC-was-zero tag at bit 10. The three processor push addresses load different entries:
  - address 0 loads the byte with all tags clear;
  - address 1 loads the byte with the mark tag set;
  - address 2 loads 0x200 (insert-CRC tag, byte zero).
  The pop port shows the oldest entry, or all zeros when the FIFO is empty.
- R2: The FIFO holds two entries in first-in first-out order. A push into a full FIFO fails and leaves the contents unchanged. A pop from an empty FIFO fails. The pop port and push port raise their fail outputs in the cycle of such a request.
- R3: A read of address 0 does three things:
  - it returns the oldest byte and pops it;
  - if the FIFO was empty, it returns 0xFF and reports error bit 2;
  - if the popped entry carries a mark tag, it reports error bit 1.
- R4: A read of address 1 returns and pops the oldest byte like address 0. It reports only the empty case (error bit 2), never the mark case.
- R5: A processor push into a full FIFO reports error bit 2. A reported error is stored only while the error register is zero, so the first error is kept. A read of address 2 returns the error register and clears it.
- R6: The handshake register (read at address 7) has these bits:
  - bit 0: the mark tag of the newest entry;
  - bit 1: set when the newest entry's CRC-was-zero tag is clear;
  - bits 1:0 are zero when the FIFO is empty;
  - bit 3: set when write protect is active or no drive is present;
  - bit 5: set when the error register is non-zero;
  - all other low bits are zero.
- R7: Handshake bits 7:6 depend on the direction in mode bit 4. With bit 4 set (write direction), they read 11 for an empty FIFO and 10 for one entry. With bit 4 clear (read direction), they read 11 for a full FIFO and 10 for one entry. All other levels read 00.
- R8: Address 3 reaches the parameter RAM at the current index. A write stores the byte, a read returns the stored byte, and each access advances the index by one, modulo 16.
- R9: The mode register is written at two addresses:
  - writing address 6 clears the mode bits set in the data;
  - writing address 7 sets them.
  Reading address 6 returns the mode. While mode bit 0 is set, the FIFO is emptied at every clock edge. Reads of addresses 4 and 5 return zero, and the read data is zero when no read strobe is high.
- R10: Drive select equals mode bits 2:1 when mode bit 7 is set, and zero otherwise. Head select equals mode bit 5.
- R11: A processor access to the FIFO wins over the external port on the same side in the same cycle. A processor push blocks the external push, and a processor pop blocks the external pop. The blocked port raises its fail output.
- R12: A synchronous active-high reset empties the FIFO and clears the error register, the parameter index and the mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 3 | Register address |
| rdStrobe | input | 1 | Register read access this cycle |
| wrStrobe | input | 1 | Register write access this cycle |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (zero without read strobe) |
| engPushReq | input | 1 | Deserializer push request |
| engPushEntry | input | 11 | Tagged entry to push |
| engPushFail | output | 1 | Push refused (full or processor push) |
| engPopReq | input | 1 | Serializer pop request |
| engPopEntry | output | 11 | Oldest tagged entry, zero when empty |
| engPopFail | output | 1 | Pop refused (empty or processor pop) |
| writeProtect | input | 1 | Medium is write protected |
| drivePresent | input | 1 | A drive is attached |
| driveSel | output | 2 | Selected drive, zero when selection disabled |
| headSel | output | 1 | Head select |

## Verification
The FIFO is filled and drained in directed order with plain, marked and CRC-token entries. This separates tag encoding from ordering, and separates the mark-read error from the empty-read error. The error register is then driven through sequences where a second, different error follows the first, which shows whether only the first one sticks. Same-cycle collisions between the processor and the external ports, and flushes through mode bit 0, are tried at each FIFO level. A long random phase then mixes all addresses, both directions and the write-protect inputs against a queue-based model, so that each handshake coding is seen at every level.

// File: rtl/fdcreg_pkg.sv
package fdcreg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BYTE_W = 8;

  // register addresses; read and write meaning share some of them
  localparam logic [2:0] ADR_DATA  = 3'd0;
  localparam logic [2:0] ADR_MARK  = 3'd1;
  localparam logic [2:0] ADR_CRCER = 3'd2; // write: CRC token, read: error
  localparam logic [2:0] ADR_PARAM = 3'd3;
  localparam logic [2:0] ADR_MCLR  = 3'd6; // write: clear mode bits, read: mode
  localparam logic [2:0] ADR_MSET  = 3'd7; // write: set mode bits, read: handshake

  localparam logic [BYTE_W-1:0] ERR_MARKRD = 8'h02;
  localparam logic [BYTE_W-1:0] ERR_ACCESS = 8'h04;

  localparam int MODE_FLUSH = 0;
  localparam int MODE_WRDIR = 4;
  localparam int MODE_HEAD  = 5;
  localparam int MODE_SELEN = 7;

  typedef struct packed {
    logic              crcZero;
    logic              crcIns;
    logic              mark;
    logic [BYTE_W-1:0] data;
  } tagEntry_t;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic              flush;
    logic              parWr;
    logic              parRd;
    tagEntry_t         pushEntry;
    logic [BYTE_W-1:0] parData;
  } dpStrobe_t;
endpackage

// File: rtl/fdcreg_dp.sv
module fdcreg_dp
  import fdcreg_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int PARAMS = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(PARAMS)
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         stb,
  output tagEntry_t         headEntry,
  output tagEntry_t         newestEntry,
  output logic [CW-1:0]     count,
  output logic [BYTE_W-1:0] paramOut
);
  timeunit 1ns;
  timeprecision 1ps;

  tagEntry_t         slots [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [BYTE_W-1:0] pram [PARAMS];
  logic [IW-1:0]     pIdx;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] prevPtr(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  // storage slots, one write enable each
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.push && wrPtr == PW'(i))
        slots[i] <= stb.pushEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign headEntry   = slots[rdPtr];
  assign newestEntry = slots[prevPtr(wrPtr)];

  // parameter RAM with self-advancing index
  always_ff @(posedge clk) begin
    if (stb.parWr)
      pram[pIdx] <= stb.parData;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pIdx <= '0;
    else if (stb.parWr || stb.parRd)
      pIdx <= pIdx + 1'b1;
  end

  assign paramOut = pram[pIdx];
endmodule

// File: rtl/fdcreg_ctrl.sv
module fdcreg_ctrl
  import fdcreg_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        regAddr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              engPushReq,
  input  tagEntry_t         engPushEntry,
  input  logic              engPopReq,
  input  logic [CW-1:0]     fifoCount,
  input  tagEntry_t         headEntry,
  input  tagEntry_t         newestEntry,
  input  logic [BYTE_W-1:0] paramOut,
  input  logic              writeProtect,
  input  logic              drivePresent,
  output dpStrobe_t         stb,
  output logic [BYTE_W-1:0] rdData,
  output logic              engPushFail,
  output logic              engPopFail,
  output tagEntry_t         engPopEntry,
  output logic [1:0]        driveSel,
  output logic              headSel,
  output logic [BYTE_W-1:0] errState,
  output logic [BYTE_W-1:0] modeState
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              isFull, isEmpty, isOne;
  logic              cpuPush, cpuPop;
  tagEntry_t         cpuEntry;
  logic [BYTE_W-1:0] errHit, errQ, modeQ, handshake, readMux;

  assign isFull  = (fifoCount == CW'(DEPTH));
  assign isEmpty = (fifoCount == '0);
  assign isOne   = (fifoCount == CW'(1));

  assign cpuPush = wrStrobe && (regAddr == ADR_DATA || regAddr == ADR_MARK ||
                                regAddr == ADR_CRCER);
  assign cpuPop  = rdStrobe && (regAddr == ADR_DATA || regAddr == ADR_MARK);

  always_comb begin
    cpuEntry = '0;
    case (regAddr)
      ADR_DATA: cpuEntry.data = wrData;
      ADR_MARK: begin
        cpuEntry.mark = 1'b1;
        cpuEntry.data = wrData;
      end
      ADR_CRCER: cpuEntry.crcIns = 1'b1;
      default: cpuEntry = '0;
    endcase
  end

  // strobes toward the datapath
  always_comb begin
    stb           = '0;
    stb.push      = (cpuPush || engPushReq) && !isFull;
    stb.pushEntry = cpuPush ? cpuEntry : engPushEntry;
    stb.pop       = (cpuPop || engPopReq) && !isEmpty;
    stb.flush     = modeQ[MODE_FLUSH];
    stb.parWr     = wrStrobe && regAddr == ADR_PARAM;
    stb.parRd     = rdStrobe && regAddr == ADR_PARAM;
    stb.parData   = wrData;
  end

  assign engPushFail = engPushReq && (cpuPush || isFull);
  assign engPopFail  = engPopReq && (cpuPop || isEmpty);
  assign engPopEntry = isEmpty ? '0 : headEntry;

  // error sources of this cycle
  always_comb begin
    errHit = '0;
    if (cpuPush && isFull)  errHit = errHit | ERR_ACCESS;
    if (cpuPop && isEmpty)  errHit = errHit | ERR_ACCESS;
    if (rdStrobe && regAddr == ADR_DATA && !isEmpty && headEntry.mark)
      errHit = errHit | ERR_MARKRD;
  end

  always_ff @(posedge clk) begin
    if (rst)
      errQ <= '0;
    else if (rdStrobe && regAddr == ADR_CRCER)
      errQ <= '0;
    else if (errQ == '0)
      errQ <= errHit;
  end

  always_ff @(posedge clk) begin
    if (rst)
      modeQ <= '0;
    else if (wrStrobe && regAddr == ADR_MCLR)
      modeQ <= modeQ & ~wrData;
    else if (wrStrobe && regAddr == ADR_MSET)
      modeQ <= modeQ | wrData;
  end

  always_comb begin
    handshake = '0;
    if (!isEmpty) begin
      handshake[0] = newestEntry.mark;
      handshake[1] = !newestEntry.crcZero;
    end
    handshake[3] = writeProtect || !drivePresent;
    handshake[5] = (errQ != '0);
    if (modeQ[MODE_WRDIR]) begin
      if (isEmpty)    handshake[7:6] = 2'b11;
      else if (isOne) handshake[7:6] = 2'b10;
    end else begin
      if (isFull)     handshake[7:6] = 2'b11;
      else if (isOne) handshake[7:6] = 2'b10;
    end
  end

  always_comb begin
    case (regAddr)
      ADR_DATA, ADR_MARK: readMux = isEmpty ? 8'hFF : headEntry.data;
      ADR_CRCER:          readMux = errQ;
      ADR_PARAM:          readMux = paramOut;
      ADR_MCLR:           readMux = modeQ;
      ADR_MSET:           readMux = handshake;
      default:            readMux = '0;
    endcase
  end

  assign rdData    = rdStrobe ? readMux : '0;
  assign driveSel  = modeQ[MODE_SELEN] ? modeQ[2:1] : 2'b00;
  assign headSel   = modeQ[MODE_HEAD];
  assign errState  = errQ;
  assign modeState = modeQ;
endmodule

// File: rtl/fdc_regset.sv
module fdc_regset
  import fdcreg_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int PARAMS = 16,
  localparam int EW = 3 + BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        regAddr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              engPushReq,
  input  logic [EW-1:0]     engPushEntry,
  output logic              engPushFail,
  input  logic              engPopReq,
  output logic [EW-1:0]     engPopEntry,
  output logic              engPopFail,
  input  logic              writeProtect,
  input  logic              drivePresent,
  output logic [1:0]        driveSel,
  output logic              headSel
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(DEPTH + 1);

  dpStrobe_t         stb;
  tagEntry_t         headEntry, newestEntry, popEntry;
  logic [CW-1:0]     fifoCount;
  logic [BYTE_W-1:0] paramOut, errState, modeState;

  fdcreg_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .regAddr(regAddr), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .wrData(wrData), .engPushReq(engPushReq),
    .engPushEntry(tagEntry_t'(engPushEntry)), .engPopReq(engPopReq),
    .fifoCount(fifoCount), .headEntry(headEntry), .newestEntry(newestEntry),
    .paramOut(paramOut), .writeProtect(writeProtect),
    .drivePresent(drivePresent), .stb(stb), .rdData(rdData),
    .engPushFail(engPushFail), .engPopFail(engPopFail),
    .engPopEntry(popEntry), .driveSel(driveSel), .headSel(headSel),
    .errState(errState), .modeState(modeState)
  );

  fdcreg_dp #(.DEPTH(DEPTH), .PARAMS(PARAMS)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .headEntry(headEntry),
    .newestEntry(newestEntry), .count(fifoCount), .paramOut(paramOut)
  );

  assign engPopEntry = popEntry;
endmodule

// File: rtl/fdc_regset_chk.sv
module fdc_regset_chk #(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    regAddr,
  input logic          rdStrobe,
  input logic [7:0]    rdData,
  input logic          engPushReq,
  input logic          engPushFail,
  input logic          engPopReq,
  input logic          engPopFail,
  input logic [1:0]    driveSel,
  input logic [CW-1:0] fifoCount,
  input logic [7:0]    errState,
  input logic [7:0]    modeState
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= CW'(DEPTH)); // R2

  AST_PUSH_FULL_FAILS: assert property (@(posedge clk) disable iff (rst)
    (engPushReq && fifoCount == CW'(DEPTH)) |-> engPushFail); // R2

  AST_POP_EMPTY_FAILS: assert property (@(posedge clk) disable iff (rst)
    (engPopReq && fifoCount == '0) |-> engPopFail); // R2

  AST_FIRST_ERROR_KEPT: assert property (@(posedge clk) disable iff (rst)
    (errState != 8'h00 && !(rdStrobe && regAddr == 3'd2)) |=> errState == $past(errState)); // R5

  AST_ERROR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && regAddr == 3'd2) |=> errState == 8'h00); // R5

  AST_HS_READ_FULL: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && regAddr == 3'd7 && !modeState[4] && fifoCount == CW'(DEPTH))
      |-> rdData[7:6] == 2'b11); // R7

  AST_HS_WRITE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && regAddr == 3'd7 && modeState[4] && fifoCount == '0)
      |-> rdData[7:6] == 2'b11); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    modeState[0] |=> fifoCount == '0); // R9

  AST_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !modeState[7] |-> driveSel == 2'b00); // R10
endmodule

bind fdc_regset fdc_regset_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .regAddr(regAddr), .rdStrobe(rdStrobe),
  .rdData(rdData), .engPushReq(engPushReq), .engPushFail(engPushFail),
  .engPopReq(engPopReq), .engPopFail(engPopFail), .driveSel(driveSel),
  .fifoCount(fifoCount), .errState(errState), .modeState(modeState)
);

// File: tb/sim_fdc_regset.sv
module sim_fdc_regset;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  regAddr = '0;
  logic        rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        engPushReq = 1'b0, engPopReq = 1'b0;
  logic [10:0] engPushEntry = '0;
  logic [10:0] engPopEntry;
  logic        engPushFail, engPopFail;
  logic        writeProtect = 1'b0, drivePresent = 1'b1;
  logic [1:0]  driveSel;
  logic        headSel;

  fdc_regset u0 (
    .clk(clk), .rst(rst), .regAddr(regAddr), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .wrData(wrData), .rdData(rdData),
    .engPushReq(engPushReq), .engPushEntry(engPushEntry),
    .engPushFail(engPushFail), .engPopReq(engPopReq),
    .engPopEntry(engPopEntry), .engPopFail(engPopFail),
    .writeProtect(writeProtect), .drivePresent(drivePresent),
    .driveSel(driveSel), .headSel(headSel)
  );

  always #4 clk = ~clk; // 125 MHz

  // behavioural reference state
  logic [10:0] mq[$];
  logic [7:0]  mErr = '0, mMode = '0;
  logic [7:0]  mPar [16];
  int          mIdx = 0;
  int          nChk = 0, nBad = 0;
  string       note = "";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s%s actual=%h expected=%h at %0t", note, tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelHs();
    logic [7:0] h = '0;
    if (mq.size() > 0) begin
      h[0] = mq[mq.size()-1][8];
      h[1] = !mq[mq.size()-1][10];
    end
    h[3] = writeProtect || !drivePresent;
    h[5] = (mErr != 0);
    if (mMode[4]) begin
      if (mq.size() == 0) h[7:6] = 2'b11;
      else if (mq.size() == 1) h[7:6] = 2'b10;
    end else begin
      if (mq.size() == 2) h[7:6] = 2'b11;
      else if (mq.size() == 1) h[7:6] = 2'b10;
    end
    return h;
  endfunction

  function automatic logic [7:0] modelRd();
    if (!rdStrobe) return 8'h00;
    case (regAddr)
      3'd0, 3'd1: return (mq.size() == 0) ? 8'hFF : mq[0][7:0];
      3'd2: return mErr;
      3'd3: return mPar[mIdx];
      3'd6: return mMode;
      3'd7: return modelHs();
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rdTag();
    case (regAddr)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R8";
      3'd7: return "R6,R7";
      default: return "R9";
    endcase
  endfunction

  task automatic modelStep();
    bit          cpuPush, cpuPop, doPush, doPop;
    int          sz;
    logic [7:0]  errHit;
    logic [10:0] ent;
    if (rst) begin
      mq.delete();
      mErr = 0; mMode = 0; mIdx = 0;
      return;
    end
    sz      = mq.size();
    cpuPush = wrStrobe && regAddr <= 3'd2;
    cpuPop  = rdStrobe && regAddr <= 3'd1;
    errHit  = 0;
    if (cpuPush && sz == 2) errHit |= 8'h04;
    if (cpuPop && sz == 0)  errHit |= 8'h04;
    if (rdStrobe && regAddr == 3'd0 && sz > 0 && mq[0][8]) errHit |= 8'h02;
    doPush = (cpuPush || engPushReq) && sz < 2;
    doPop  = (cpuPop || engPopReq) && sz > 0;
    if (cpuPush)
      ent = (regAddr == 3'd0) ? {3'b000, wrData} :
            (regAddr == 3'd1) ? {3'b001, wrData} : 11'h200;
    else
      ent = engPushEntry;
    if (doPop) void'(mq.pop_front());
    if (doPush) mq.push_back(ent);
    if (mMode[0]) mq.delete();
    if (rdStrobe && regAddr == 3'd2) mErr = 0;
    else if (mErr == 0) mErr = errHit;
    if (wrStrobe && regAddr == 3'd3) mPar[mIdx] = wrData;
    if ((wrStrobe || rdStrobe) && regAddr == 3'd3) mIdx = (mIdx + 1) % 16;
    if (wrStrobe && regAddr == 3'd6) mMode = mMode & ~wrData;
    else if (wrStrobe && regAddr == 3'd7) mMode = mMode | wrData;
  endtask

  task automatic op(input bit r, input bit w, input logic [2:0] a,
                    input logic [7:0] d = 8'h00, input bit ep = 0,
                    input logic [10:0] ee = 11'h000, input bit eo = 0);
    bit cpuPush, cpuPop;
    @(negedge clk);
    rdStrobe = r; wrStrobe = w; regAddr = a; wrData = d;
    engPushReq = ep; engPushEntry = ee; engPopReq = eo;
    #1;
    cpuPush = w && a <= 3'd2;
    cpuPop  = r && a <= 3'd1;
    chk(rdTag(), 32'(rdData), 32'(modelRd()));
    chk("R2,R11 push fail", 32'(engPushFail), 32'(ep && (cpuPush || mq.size() == 2)));
    chk("R2,R11 pop fail", 32'(engPopFail), 32'(eo && (cpuPop || mq.size() == 0)));
    chk("R1 pop entry", 32'(engPopEntry), 32'((mq.size() > 0) ? mq[0] : 11'h000));
    chk("R10 drive", 32'(driveSel), 32'(mMode[7] ? mMode[2:1] : 2'b00));
    chk("R10 head", 32'(headSel), 32'(mMode[5]));
    @(posedge clk);
    modelStep();
    note = "";
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    modelStep();
    @(negedge clk);
    rst = 1'b0;

    note = "R12 ";
    op(1, 0, 3'd7);                     // handshake after reset
    note = "R12 ";
    op(1, 0, 3'd2);                     // error after reset

    // R8: parameter RAM fill and wrapping read-back
    for (int i = 0; i < 16; i++) op(0, 1, 3'd3, 8'h30 + 8'(i));
    for (int i = 0; i < 18; i++) op(1, 0, 3'd3);

    // R1 R2 R5: push plain, marked, then overflow
    op(0, 1, 3'd0, 8'h5A);
    op(1, 0, 3'd7);
    op(0, 1, 3'd1, 8'hA1);
    op(1, 0, 3'd7);
    op(0, 1, 3'd0, 8'h77);              // overflow -> error bit 2
    op(0, 1, 3'd2);                     // second overflow, first error kept
    op(1, 0, 3'd2);                     // read clears
    // R3: pop plain then marked (mark error)
    op(1, 0, 3'd0);
    op(1, 0, 3'd0);
    op(1, 0, 3'd7);
    op(1, 0, 3'd0);                     // empty read, error kept as mark error
    op(1, 0, 3'd2);
    // R4: empty mark read
    op(1, 0, 3'd1);
    op(1, 0, 3'd2);
    // R4: marked entry via mark register raises nothing
    op(0, 1, 3'd1, 8'hC3);
    op(1, 0, 3'd1);
    op(1, 0, 3'd2);
    // R1: CRC token seen on the pop port
    op(0, 1, 3'd2);
    op(0, 0, 3'd0, 8'h00, 0, 11'h000, 1);
    // R6: deserializer entry with CRC-zero tag, write protect, no drive
    op(0, 0, 3'd0, 8'h00, 1, 11'h4E5);
    op(1, 0, 3'd7);
    writeProtect = 1'b1;
    op(1, 0, 3'd7);
    writeProtect = 1'b0; drivePresent = 1'b0;
    op(1, 0, 3'd7);
    drivePresent = 1'b1;
    // R11: collisions
    op(0, 1, 3'd0, 8'h11, 1, 11'h122);
    op(1, 0, 3'd0, 8'h00, 0, 11'h000, 1);
    op(1, 0, 3'd0, 8'h00, 0, 11'h000, 1);
    // R7: write direction levels
    op(0, 1, 3'd7, 8'h10);
    op(1, 0, 3'd7);
    op(0, 1, 3'd0, 8'h01);
    op(1, 0, 3'd7);
    op(0, 1, 3'd0, 8'h02);
    op(1, 0, 3'd7);
    // R9: flush via mode bit 0
    op(0, 1, 3'd7, 8'h01);
    op(1, 0, 3'd6);
    op(0, 1, 3'd0, 8'h03);
    op(1, 0, 3'd7);
    op(0, 1, 3'd6, 8'h11);
    op(1, 0, 3'd4);
    // R10: drive and head select
    op(0, 1, 3'd7, 8'h24);
    op(0, 1, 3'd7, 8'h80);
    op(0, 1, 3'd6, 8'h80);

    // random mixture
    for (int n = 0; n < 3000; n++) begin
      int          kind;
      logic [2:0]  a;
      logic [7:0]  d;
      kind = $urandom % 3;
      a = 3'($urandom);
      d = 8'($urandom);
      if (a == 3'd7 && ($urandom % 4) != 0) d[0] = 1'b0;
      if (($urandom % 16) == 0) writeProtect = ~writeProtect;
      if (($urandom % 16) == 0) drivePresent = ~drivePresent;
      op(kind == 1, kind == 2, a, d, ($urandom % 3) == 0, 11'($urandom),
         ($urandom % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule